// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped slave on a simple register bus. A host processor uses it to hand commands to an on-chip management controller and to collect the results. The host first loads request data into a small outbound buffer. It then writes one packed command word, which latches the word, marks the mailbox busy and sends a single-cycle doorbell pulse to the controller.

The controller reads the latched command and the outbound buffer through a dedicated side port. It may deposit response words into an inbound buffer. It finishes the command with a done strobe that carries an error flag and an 8-bit error code. Completion clears busy and records the error outcome in the status word. When the command asked for it, completion also raises a one-cycle interrupt pulse that the host never has to clear. The host polls busy, checks the error flag, and then reads the response as whole words or as single bytes.

All host reads have one cycle of latency: the data appears in the cycle after the read strobe. The window covers 256 bytes. Locations that are not mapped, and the two write-only areas, read as zero.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, busy, error, the error code and the latched command are all zero, so the status word reads as the initiator identity in bits 15:8 and zero elsewhere. Doorbell and interrupt are low.
- R2: A word write to byte offset 0x00 while idle latches the full 32-bit command on `ctl_cmd` and sets busy (status bit 0). It also drives `ctl_doorbell` high for exactly the one cycle after the write.
- R3: A write to offset 0x00 while busy is dropped. No doorbell is raised, `ctl_cmd` keeps its value and the status word is unchanged.
- R4: The status word at offset 0x04 has this layout:
  - bit 0: busy
  - bit 1: error
  - bits 7:4: the sub-command field (bits 15:12) of the latched command
  - bits 15:8: the INITIATOR_ID parameter
  - bits 23:16: the error code
  - all other bits: zero

  A `ctl_done` pulse while busy clears busy and loads the error bit from `ctl_err` and the error code from `ctl_err_code`.
- R5: An accepted command write clears the error bit and the error code.
- R6: When bit 8 (interrupt-on-completion) of the latched command is set, `irq_done` is high for exactly the one cycle after the completing `ctl_done`. When bit 8 is clear, it stays low.
- R7: A word write to offset 0x80 + 4*i (i below WBUF_WORDS) stores the word. The controller sees that word on `ctl_wbuf_data` when `ctl_wbuf_idx` = i.
- R8: A `ctl_rbuf_we` pulse stores `ctl_rbuf_data` into inbound word `ctl_rbuf_idx`. The inbound buffer starts right after the outbound one (0x90 by default).
  - A word read (`bus_rd_byte` = 0) at base + 4*i returns word i.
  - A byte read (`bus_rd_byte` = 1) returns the byte in lane `bus_addr[1:0]` (lane 0 = bits 7:0) in bits 7:0, with bits 31:8 zero.
- R9: The following reads return zero: offset 0x00, the outbound buffer, and any offset outside the status register and the inbound buffer. Writes to the status register and to the inbound buffer are dropped.
- R10: Read data is registered. It shows the addressed value in the cycle after `bus_rd_en`, and it is zero in any cycle that follows a cycle without `bus_rd_en`.
- R11: A `ctl_done` pulse while idle is ignored. Busy, error, the error code and `irq_done` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_we | input | 1 | Word write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_byte | input | 1 | 1 = byte read, 0 = word read |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| ctl_doorbell | output | 1 | One-cycle pulse on an accepted command |
| ctl_cmd | output | 32 | Latched command word |
| ctl_wbuf_idx | input | WB_IDX_W | Outbound buffer word select |
| ctl_wbuf_data | output | 32 | Selected outbound word |
| ctl_rbuf_we | input | 1 | Inbound buffer write strobe |
| ctl_rbuf_idx | input | RB_IDX_W | Inbound buffer word select |
| ctl_rbuf_data | input | 32 | Inbound buffer write data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Error flag captured at completion |
| ctl_err_code | input | 8 | Error code captured at completion |
| irq_done | output | 1 | One-cycle completion interrupt |

## Verification
The bench uses the default build: four outbound words, four inbound words and initiator identity 0x5A. This puts the inbound buffer at 0x90 and its end at 0xA0, so the checks can probe the outbound/inbound boundary and the first unmapped word right after the inbound buffer. The non-zero identity makes the status-byte layout visible even while busy and error are both clear. The bench walks a full command cycle twice, once with the completion interrupt requested and once without. It also exercises the corner cases around the busy flag: a second command posted while busy, and a completion strobe arriving while idle.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;

    localparam int WIN_ADDR_W     = 8;
    localparam int WORD_W         = 32;
    localparam int CMD_WORD_ADDR  = 0;
    localparam int STAT_WORD_ADDR = 1;
    localparam int WBUF_WORD_BASE = 32;   // byte offset 0x80

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] size;
        logic [3:0] sub_id;
        logic [2:0] rsvd_lo;
        logic       ioc;
        logic [7:0] opcode;
    } cmd_word_t;

    typedef enum logic [2:0] {
        RGN_CMD,
        RGN_STAT,
        RGN_WBUF,
        RGN_RBUF,
        RGN_NONE
    } region_t;

    function automatic region_t decode_region(input logic [WIN_ADDR_W-3:0] waddr,
                                              input int wb_words,
                                              input int rb_words);
        int w;
        w = int'(waddr);
        if (w == CMD_WORD_ADDR)
            return RGN_CMD;
        else if (w == STAT_WORD_ADDR)
            return RGN_STAT;
        else if (w >= WBUF_WORD_BASE && w < WBUF_WORD_BASE + wb_words)
            return RGN_WBUF;
        else if (w >= WBUF_WORD_BASE + wb_words &&
                 w < WBUF_WORD_BASE + wb_words + rb_words)
            return RGN_RBUF;
        return RGN_NONE;
    endfunction

    function automatic logic [WORD_W-1:0] make_status(input cmd_word_t  c,
                                                      input logic       busy,
                                                      input logic       err,
                                                      input logic [7:0] code,
                                                      input logic [7:0] init_id);
        return {8'h00, code, init_id, c.sub_id, 2'b00, err, busy};
    endfunction

endpackage

// File: rtl/mb_word_buffer.sv
module mb_word_buffer #(
    parameter int WORDS = 4,
    parameter int WIDTH = 32,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (wr_en && int'(wr_idx) == g)
                mem[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < WORDS)
            rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/mb_cmd_ctrl.sv
module mb_cmd_ctrl
    import cmd_mailbox_pkg::*;
#(
    parameter logic [7:0] INITIATOR_ID = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              done,
    input  logic              done_err,
    input  logic [7:0]        done_code,
    output logic              busy,
    output logic              doorbell,
    output logic              irq,
    output cmd_word_t         cmd_q,
    output logic [WORD_W-1:0] status
);

    logic       err_q;
    logic [7:0] code_q;
    logic       accept;
    logic       finish;

    assign accept = cmd_wr && !busy;
    assign finish = done && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            doorbell <= 1'b0;
            irq      <= 1'b0;
            cmd_q    <= '0;
            err_q    <= 1'b0;
            code_q   <= '0;
        end else begin
            doorbell <= accept;
            irq      <= finish && cmd_q.ioc;
            if (accept) begin
                cmd_q  <= cmd_word_t'(cmd_wdata);
                busy   <= 1'b1;
                err_q  <= 1'b0;
                code_q <= '0;
            end else if (finish) begin
                busy   <= 1'b0;
                err_q  <= done_err;
                code_q <= done_code;
            end
        end
    end

    assign status = make_status(cmd_q, busy, err_q, code_q, INITIATOR_ID);

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import cmd_mailbox_pkg::*;
#(
    parameter int         WBUF_WORDS   = 4,
    parameter int         RBUF_WORDS   = 4,
    parameter logic [7:0] INITIATOR_ID = 8'h5A,
    localparam int WB_IDX_W = (WBUF_WORDS > 1) ? $clog2(WBUF_WORDS) : 1,
    localparam int RB_IDX_W = (RBUF_WORDS > 1) ? $clog2(RBUF_WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIN_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic                  bus_rd_en,
    input  logic                  bus_rd_byte,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  ctl_doorbell,
    output logic [WORD_W-1:0]     ctl_cmd,
    input  logic [WB_IDX_W-1:0]   ctl_wbuf_idx,
    output logic [WORD_W-1:0]     ctl_wbuf_data,
    input  logic                  ctl_rbuf_we,
    input  logic [RB_IDX_W-1:0]   ctl_rbuf_idx,
    input  logic [WORD_W-1:0]     ctl_rbuf_data,
    input  logic                  ctl_done,
    input  logic                  ctl_err,
    input  logic [7:0]            ctl_err_code,
    output logic                  irq_done
);

    localparam int RBUF_WORD_BASE = WBUF_WORD_BASE + WBUF_WORDS;

    logic [WIN_ADDR_W-3:0] word_addr;
    region_t               region;
    logic                  host_cmd_wr;
    logic                  host_wbuf_wr;
    logic [WB_IDX_W-1:0]   host_wb_idx;
    logic [RB_IDX_W-1:0]   host_rb_idx;
    logic [WORD_W-1:0]     rbuf_word;
    logic [WORD_W-1:0]     status_word;
    logic [WORD_W-1:0]     sel_word;
    logic [WORD_W-1:0]     lane_shift;
    logic [WORD_W-1:0]     rd_next;
    logic                  busy;
    cmd_word_t             cmd_q;

    assign word_addr    = bus_addr[WIN_ADDR_W-1:2];
    assign region       = decode_region(word_addr, WBUF_WORDS, RBUF_WORDS);
    assign host_cmd_wr  = bus_we && (region == RGN_CMD);
    assign host_wbuf_wr = bus_we && (region == RGN_WBUF);
    assign host_wb_idx  = WB_IDX_W'(int'(word_addr) - WBUF_WORD_BASE);
    assign host_rb_idx  = RB_IDX_W'(int'(word_addr) - RBUF_WORD_BASE);

    mb_cmd_ctrl #(
        .INITIATOR_ID(INITIATOR_ID)
    ) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (host_cmd_wr),
        .cmd_wdata(bus_wdata),
        .done     (ctl_done),
        .done_err (ctl_err),
        .done_code(ctl_err_code),
        .busy     (busy),
        .doorbell (ctl_doorbell),
        .irq      (irq_done),
        .cmd_q    (cmd_q),
        .status   (status_word)
    );

    assign ctl_cmd = WORD_W'(cmd_q);

    mb_word_buffer #(
        .WORDS(WBUF_WORDS),
        .WIDTH(WORD_W)
    ) i_wbuf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (host_wbuf_wr),
        .wr_idx (host_wb_idx),
        .wr_data(bus_wdata),
        .rd_idx (ctl_wbuf_idx),
        .rd_data(ctl_wbuf_data)
    );

    mb_word_buffer #(
        .WORDS(RBUF_WORDS),
        .WIDTH(WORD_W)
    ) i_rbuf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctl_rbuf_we),
        .wr_idx (ctl_rbuf_idx),
        .wr_data(ctl_rbuf_data),
        .rd_idx (host_rb_idx),
        .rd_data(rbuf_word)
    );

    always_comb begin
        unique case (region)
            RGN_STAT: sel_word = status_word;
            RGN_RBUF: sel_word = rbuf_word;
            default:  sel_word = '0;
        endcase
        lane_shift = sel_word >> {bus_addr[1:0], 3'b000};
        rd_next    = bus_rd_byte ? {24'h000000, lane_shift[7:0]} : sel_word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= bus_rd_en ? rd_next : '0;
    end

endmodule

// File: rtl/mb_cmd_checker.sv
module mb_cmd_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr,
    input logic        busy,
    input logic        doorbell,
    input logic        done,
    input logic        irq,
    input logic        rd_en,
    input logic [31:0] rdata,
    input logic [31:0] cmd
);

    AST_DOORBELL_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        doorbell |-> busy);                                   // R2
    AST_DOORBELL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        doorbell |=> !doorbell);                              // R2
    AST_BUSY_CMD_NO_BELL: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> !doorbell);                      // R3
    AST_BUSY_CMD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(cmd));                   // R3
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);                            // R4
    AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(busy && done));                         // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);                                        // R6
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == 32'h0));                         // R10
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!busy && done && !cmd_wr) |=> (!busy && !irq));      // R11

endmodule

bind cmd_mailbox mb_cmd_checker i_checker (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (host_cmd_wr),
    .busy    (busy),
    .doorbell(ctl_doorbell),
    .done    (ctl_done),
    .irq     (irq_done),
    .rd_en   (bus_rd_en),
    .rdata   (bus_rdata),
    .cmd     (ctl_cmd)
);

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] INIT_ID    = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic        bus_rd_byte = 1'b0;
    logic [31:0] bus_rdata;
    logic        ctl_doorbell;
    logic [31:0] ctl_cmd;
    logic [1:0]  ctl_wbuf_idx = '0;
    logic [31:0] ctl_wbuf_data;
    logic        ctl_rbuf_we = 1'b0;
    logic [1:0]  ctl_rbuf_idx = '0;
    logic [31:0] ctl_rbuf_data = '0;
    logic        ctl_done = 1'b0;
    logic        ctl_err = 1'b0;
    logic [7:0]  ctl_err_code = '0;
    logic        irq_done;

    int checks = 0;
    int errors = 0;
    logic        seen_bell;
    logic        seen_irq;
    logic [31:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox #(
        .WBUF_WORDS  (4),
        .RBUF_WORDS  (4),
        .INITIATOR_ID(INIT_ID)
    ) i_cmd_mailbox (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rd_en    (bus_rd_en),
        .bus_rd_byte  (bus_rd_byte),
        .bus_rdata    (bus_rdata),
        .ctl_doorbell (ctl_doorbell),
        .ctl_cmd      (ctl_cmd),
        .ctl_wbuf_idx (ctl_wbuf_idx),
        .ctl_wbuf_data(ctl_wbuf_data),
        .ctl_rbuf_we  (ctl_rbuf_we),
        .ctl_rbuf_idx (ctl_rbuf_idx),
        .ctl_rbuf_data(ctl_rbuf_data),
        .ctl_done     (ctl_done),
        .ctl_err      (ctl_err),
        .ctl_err_code (ctl_err_code),
        .irq_done     (irq_done)
    );

    function automatic logic [31:0] exp_status(input logic [7:0] code, input logic [3:0] sub,
                                               input logic err, input logic busy);
        return {8'h00, code, INIT_ID, sub, 2'b00, err, busy};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        seen_bell = ctl_doorbell;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic as_byte);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1; bus_rd_byte = as_byte;
        @(negedge clk);
        bus_rd_en = 1'b0; bus_rd_byte = 1'b0;
        rd_val = bus_rdata;
    endtask

    task automatic finish_cmd(input logic err, input logic [7:0] code);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = err; ctl_err_code = code;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
        seen_irq = irq_done;
    endtask

    task automatic rbuf_fill(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        ctl_rbuf_we = 1'b1; ctl_rbuf_idx = idx; ctl_rbuf_data = d;
        @(negedge clk);
        ctl_rbuf_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "doorbell after reset", 32'(ctl_doorbell), 32'h0);
        check("R1", "irq after reset", 32'(irq_done), 32'h0);
        check("R1", "cmd after reset", ctl_cmd, 32'h0);
        bus_read(8'h04, 1'b0);
        check("R1", "status after reset", rd_val, exp_status(8'h00, 4'h0, 1'b0, 1'b0));
    endtask

    task automatic t_post_command();
        for (int i = 0; i < 4; i++) bus_write(8'h80 + 8'(4*i), 32'hA000_0000 + 32'(i));
        for (int i = 0; i < 4; i++) begin
            ctl_wbuf_idx = 2'(i);
            #1;
            check("R7", "outbound word to controller", ctl_wbuf_data, 32'hA000_0000 + 32'(i));
        end
        bus_write(8'h00, 32'h0003_21FF);
        check("R2", "doorbell on accept", 32'(seen_bell), 32'h1);
        check("R2", "latched command", ctl_cmd, 32'h0003_21FF);
        @(negedge clk);
        check("R2", "doorbell lasts one cycle", 32'(ctl_doorbell), 32'h0);
        bus_read(8'h04, 1'b0);
        check("R4", "status while busy", rd_val, exp_status(8'h00, 4'h2, 1'b0, 1'b1));
    endtask

    task automatic t_busy_ignore();
        bus_write(8'h00, 32'h0000_7055);
        check("R3", "no doorbell while busy", 32'(seen_bell), 32'h0);
        check("R3", "command kept while busy", ctl_cmd, 32'h0003_21FF);
        bus_read(8'h04, 1'b0);
        check("R3", "status kept while busy", rd_val, exp_status(8'h00, 4'h2, 1'b0, 1'b1));
    endtask

    task automatic t_complete_error();
        rbuf_fill(2'd0, 32'h4433_2211);
        rbuf_fill(2'd3, 32'hDDCC_BBAA);
        finish_cmd(1'b1, 8'h33);
        check("R6", "irq after completion with ioc", 32'(seen_irq), 32'h1);
        @(negedge clk);
        check("R6", "irq lasts one cycle", 32'(irq_done), 32'h0);
        bus_read(8'h04, 1'b0);
        check("R4", "status after error completion", rd_val, exp_status(8'h33, 4'h2, 1'b1, 1'b0));
        bus_read(8'h90, 1'b0);
        check("R8", "inbound word 0", rd_val, 32'h4433_2211);
        @(negedge clk);
        check("R10", "rdata zero after read", bus_rdata, 32'h0);
        bus_read(8'h9C, 1'b0);
        check("R8", "inbound word 3", rd_val, 32'hDDCC_BBAA);
        bus_read(8'h92, 1'b1);
        check("R8", "byte lane 2 of word 0", rd_val, 32'h0000_0033);
        bus_read(8'h9F, 1'b1);
        check("R8", "byte lane 3 of word 3", rd_val, 32'h0000_00DD);
        bus_read(8'h05, 1'b1);
        check("R4", "status byte 1 is initiator", rd_val, 32'(INIT_ID));
    endtask

    task automatic t_clear_and_no_irq();
        bus_write(8'h00, 32'h0000_1010);
        check("R2", "doorbell on second command", 32'(seen_bell), 32'h1);
        bus_read(8'h04, 1'b0);
        check("R5", "error cleared on accept", rd_val, exp_status(8'h00, 4'h1, 1'b0, 1'b1));
        finish_cmd(1'b0, 8'h00);
        check("R6", "no irq without ioc", 32'(seen_irq), 32'h0);
        bus_read(8'h04, 1'b0);
        check("R4", "status after clean completion", rd_val, exp_status(8'h00, 4'h1, 1'b0, 1'b0));
    endtask

    task automatic t_idle_done();
        finish_cmd(1'b1, 8'hEE);
        check("R11", "no irq on idle done", 32'(seen_irq), 32'h0);
        bus_read(8'h04, 1'b0);
        check("R11", "status kept on idle done", rd_val, exp_status(8'h00, 4'h1, 1'b0, 1'b0));
    endtask

    task automatic t_regions();
        bus_read(8'h00, 1'b0);
        check("R9", "command reads zero", rd_val, 32'h0);
        bus_read(8'h84, 1'b0);
        check("R9", "outbound buffer reads zero", rd_val, 32'h0);
        bus_read(8'hA0, 1'b0);
        check("R9", "word after inbound reads zero", rd_val, 32'h0);
        bus_read(8'hFC, 1'b0);
        check("R9", "top of window reads zero", rd_val, 32'h0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R9", "status write no doorbell", 32'(seen_bell), 32'h0);
        bus_read(8'h04, 1'b0);
        check("R9", "status write dropped", rd_val, exp_status(8'h00, 4'h1, 1'b0, 1'b0));
        bus_write(8'h90, 32'h1234_5678);
        bus_read(8'h90, 1'b0);
        check("R9", "inbound write dropped", rd_val, 32'h4433_2211);
        bus_write(8'hC0, 32'h0000_01AA);
        check("R9", "unmapped write no doorbell", 32'(seen_bell), 32'h0);
        check("R9", "unmapped write keeps command", ctl_cmd, 32'h0000_1010);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_post_command();
        t_busy_ignore();
        t_complete_error();
        t_clear_and_no_irq();
        t_idle_done();
        t_regions();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule